// File: doc/BRIEF.md
# Two-Width Horizontal Line Timer

This block produces the horizontal timing of one video line for a tile-based display processor. The line can be one of two widths: a narrow line with 256 active pixels or a wide line with 320 active pixels. The block advances on a pixel-clock enable. It keeps an 8-bit horizontal position that moves up by one for every two pixels. Partway through each line the position skips a range of values. From the position and a one-bit pixel phase, the block decodes the horizontal blanking flag, an active-low sync pulse and three single-cycle strobes: a horizontal interrupt, a step for the vertical line counter, and the vertical-interrupt timing point.

Software can read the position directly, and timing-sensitive code polls it to find the start of blanking. The width select is sampled only when the position wraps to zero, so the new width always starts on a clean line. A separate control input holds the sync output high.

Top module: `ht_hline_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its reset state after that edge: `hCount` = 0x00, pixel phase 0, `hBlank` low and `hSyncN` high. The width select is loaded from `wideMode` at the same edge.
- R2: The pixel phase toggles on each clock that has `pixEn` high, and `hCount` advances only when `pixEn` is high while the phase is 1. So every position value lasts two enabled pixels, and both `hCount` and the phase hold on clocks without `pixEn`.
- R3: Narrow line (`wideMode` = 0): `hCount` runs 0x00 to 0x93, jumps to 0xE9, runs on to 0xFF and wraps to 0x00. This is 171 positions, or 342 pixels per line.
- R4: Wide line (`wideMode` = 1): `hCount` runs 0x00 to 0xB6, jumps to 0xE4, runs on to 0xFF and wraps. This is 211 positions, or 422 pixels per line.
- R5: `wideMode` is captured only at the step from 0xFF to 0x00. A change at any other time has no effect until the next line starts.
- R6: `hBlank` goes high at the step that makes the jump. It goes low at the step that brings `hCount` to 0x06 on a narrow line or to 0x08 on a wide line.
- R7: `hIntStb` and `vIncStb` each pulse for one clock. The pulse comes on the clock that has `pixEn` high, phase 0 and `hCount` = 0x85 on a narrow line or 0xA7 on a wide line.
- R8: `vIntStb` pulses for one clock. The pulse comes on the clock that has `pixEn` high, phase 0 and `hCount` = 0x00 on a narrow line or 0x02 on a wide line.
- R9: Narrow line: `hSyncN` is low from phase 1 of 0xEC up to and including phase 0 of 0xF9. This gives a 26-pixel pulse whose falling edge comes 37 pixels after the horizontal-interrupt pixel.
- R10: Wide line: `hSyncN` is low from phase 1 of 0xE7 up to and including phase 1 of 0xF7. The falling edge comes 39 pixels after the horizontal-interrupt pixel, and the rising edge comes 20 pixels before phase 0 of 0x02.
- R11: While `syncOff` is high, `hSyncN` stays high at every position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | Pixel-clock enable, one pixel per high clock |
| wideMode | input | 1 | Width select: 0 = 256-pixel line, 1 = 320-pixel line |
| syncOff | input | 1 | Holds the sync output high while set |
| hCount | output | 8 | Horizontal position, readable |
| hBlank | output | 1 | Horizontal blanking flag |
| hSyncN | output | 1 | Horizontal sync, active low |
| hIntStb | output | 1 | Horizontal-interrupt strobe |
| vIncStb | output | 1 | Vertical-counter step strobe |
| vIntStb | output | 1 | Vertical-interrupt timing strobe |

## Verification
The bench uses the package's default decode tables. Both line widths are selected at run time, so each set of jump, blank, strobe and sync values is exercised. Random gaps in `pixEn` show that the position and phase hold during gaps and that no pixel is lost. Random width changes in the middle of a line reach the rule that the width is only taken at the wrap. Directed runs with `pixEn` held high measure the full narrow and wide line lengths between successive interrupt strobes.

// File: rtl/ht_pkg.sv
package ht_pkg;

  localparam int CNT_W = 8;
  localparam int POS_W = CNT_W + 1;   // position plus pixel phase

  // step request from control to datapath
  typedef struct packed {
    logic             advance;
    logic             jump;
    logic [CNT_W-1:0] jumpTo;
  } hStep_t;

  // decode points for one line width
  typedef struct packed {
    logic [CNT_W-1:0] lastLow;
    logic [CNT_W-1:0] jumpTo;
    logic [CNT_W-1:0] blankEnd;
    logic [CNT_W-1:0] hIntAt;
    logic [CNT_W-1:0] vIntAt;
    logic [POS_W-1:0] syncFall;   // first low pixel {count, phase}
    logic [POS_W-1:0] syncRise;   // first high pixel after the pulse
  } modeCfg_t;

  localparam modeCfg_t NARROW_CFG = '{
    lastLow:  8'h93, jumpTo: 8'hE9, blankEnd: 8'h06,
    hIntAt:   8'h85, vIntAt: 8'h00,
    syncFall: {8'hEC, 1'b1}, syncRise: {8'hF9, 1'b1}
  };

  localparam modeCfg_t WIDE_CFG = '{
    lastLow:  8'hB6, jumpTo: 8'hE4, blankEnd: 8'h08,
    hIntAt:   8'hA7, vIntAt: 8'h02,
    syncFall: {8'hE7, 1'b1}, syncRise: {8'hF8, 1'b0}
  };

  function automatic modeCfg_t cfgFor(input logic wide);
    return wide ? WIDE_CFG : NARROW_CFG;
  endfunction

endpackage

// File: rtl/ht_datapath.sv
module ht_datapath
  import ht_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  hStep_t           step,
  output logic [CNT_W-1:0] hCount
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
    end else if (step.advance) begin
      if (step.jump) hCount <= step.jumpTo;
      else           hCount <= CNT_W'(hCount + 1'b1);   // 0xFF wraps to 0x00
    end
  end

endmodule

// File: rtl/ht_control.sv
module ht_control
  import ht_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pixEn,
  input  logic             wideMode,
  input  logic             syncOff,
  input  logic [CNT_W-1:0] hCount,
  output hStep_t           step,
  output logic             hBlank,
  output logic             hSyncN,
  output logic             hIntStb,
  output logic             vIncStb,
  output logic             vIntStb
);

  logic             phase;
  logic             lineWide;
  modeCfg_t         cfg;
  logic [CNT_W-1:0] nextCount;
  logic [POS_W-1:0] pos;
  logic             firstPix;
  logic             inSync;

  assign cfg = cfgFor(lineWide);

  always_comb begin
    step.advance = pixEn & phase;
    step.jump    = step.advance & (hCount == cfg.lastLow);
    step.jumpTo  = cfg.jumpTo;
    nextCount    = step.jump ? cfg.jumpTo : CNT_W'(hCount + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      lineWide <= wideMode;
      hBlank   <= 1'b0;
    end else begin
      if (pixEn) phase <= ~phase;
      if (step.advance && (hCount == {CNT_W{1'b1}})) lineWide <= wideMode;
      if (step.jump)
        hBlank <= 1'b1;
      else if (step.advance && (nextCount == cfg.blankEnd))
        hBlank <= 1'b0;
    end
  end

  assign pos      = {hCount, phase};
  assign inSync   = (pos >= cfg.syncFall) && (pos < cfg.syncRise);
  assign hSyncN   = syncOff | ~inSync;

  assign firstPix = pixEn & ~phase;
  assign hIntStb  = firstPix & (hCount == cfg.hIntAt);
  assign vIncStb  = firstPix & (hCount == cfg.hIntAt);
  assign vIntStb  = firstPix & (hCount == cfg.vIntAt);

endmodule

// File: rtl/ht_hline_timer.sv
module ht_hline_timer
  import ht_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pixEn,
  input  logic             wideMode,
  input  logic             syncOff,
  output logic [CNT_W-1:0] hCount,
  output logic             hBlank,
  output logic             hSyncN,
  output logic             hIntStb,
  output logic             vIncStb,
  output logic             vIntStb
);

  hStep_t stepReq;

  ht_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pixEn    (pixEn),
    .wideMode (wideMode),
    .syncOff  (syncOff),
    .hCount   (hCount),
    .step     (stepReq),
    .hBlank   (hBlank),
    .hSyncN   (hSyncN),
    .hIntStb  (hIntStb),
    .vIncStb  (vIncStb),
    .vIntStb  (vIntStb)
  );

  ht_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .step   (stepReq),
    .hCount (hCount)
  );

endmodule

// File: rtl/ht_hline_timer_chk.sv
module ht_hline_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       pixEn,
  input logic       syncOff,
  input logic [7:0] hCount,
  input logic       hBlank,
  input logic       hSyncN,
  input logic       hIntStb,
  input logic       vIncStb,
  input logic       vIntStb
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (hCount == 8'h00) && !hBlank);

  // R2
  hold_without_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> $stable(hCount));

  // R3
  skipped_range_chk: assert property (@(posedge clk) disable iff (rst)
    (hCount <= 8'hB6) || (hCount >= 8'hE4));

  // R6
  blank_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hBlank) |-> (hCount >= 8'hE4));

  // R7
  hint_single_chk: assert property (@(posedge clk) disable iff (rst)
    hIntStb |=> !hIntStb);

  // R7
  vinc_pairs_hint_chk: assert property (@(posedge clk) disable iff (rst)
    hIntStb |-> vIncStb);

  // R8
  vint_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    vIntStb |-> pixEn);

  // R11
  sync_off_chk: assert property (@(posedge clk) disable iff (rst)
    syncOff |-> hSyncN);

endmodule

bind ht_hline_timer ht_hline_timer_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pixEn   (pixEn),
  .syncOff (syncOff),
  .hCount  (hCount),
  .hBlank  (hBlank),
  .hSyncN  (hSyncN),
  .hIntStb (hIntStb),
  .vIncStb (vIncStb),
  .vIntStb (vIntStb)
);

// File: tb/ht_hline_timer_test.sv
`timescale 1ns/1ps
module ht_hline_timer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pixEn = 1'b0;
  logic       wideMode = 1'b0;
  logic       syncOff = 1'b0;
  logic [7:0] hCount;
  logic       hBlank, hSyncN, hIntStb, vIncStb, vIntStb;

  int vecs = 0;
  int errs = 0;
  bit sawHint;

  // reference state
  int mCnt = 0;
  int mPh  = 0;
  bit mWide = 0;
  bit mBlank = 0;

  ht_hline_timer uut (
    .clk(clk), .rst(rst), .pixEn(pixEn), .wideMode(wideMode), .syncOff(syncOff),
    .hCount(hCount), .hBlank(hBlank), .hSyncN(hSyncN),
    .hIntStb(hIntStb), .vIncStb(vIncStb), .vIntStb(vIntStb)
  );

  always #4 clk = ~clk;

  task automatic cmp(input int act, input int exp, input string tag);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit expSyncN(int cnt, int ph, bit wide, bit off);
    int p = cnt * 2 + ph;
    if (off) return 1'b1;
    if (wide) return !((p >= 8'hE7 * 2 + 1) && (p <= 8'hF7 * 2 + 1));   // R10
    return !((p >= 8'hEC * 2 + 1) && (p <= 8'hF9 * 2));                 // R9
  endfunction

  task automatic step(input bit p, input bit w, input bit s, input bit r);
    int hAt, vAt, last;
    rst = r; pixEn = p; wideMode = w; syncOff = s;
    #1;
    hAt = mWide ? 8'hA7 : 8'h85;
    vAt = mWide ? 8'h02 : 8'h00;
    sawHint = hIntStb;
    if (!r) begin
      cmp(hCount, mCnt, "R2 R3 R4 R5 hCount");
      cmp(hBlank, mBlank, "R6 hBlank");
      cmp(hIntStb, p && mPh == 0 && mCnt == hAt, "R7 hIntStb");
      cmp(vIncStb, p && mPh == 0 && mCnt == hAt, "R7 vIncStb");
      cmp(vIntStb, p && mPh == 0 && mCnt == vAt, "R8 vIntStb");
      cmp(hSyncN, expSyncN(mCnt, mPh, mWide, s), "R9 R10 R11 hSyncN");
    end
    @(posedge clk);
    if (r) begin
      mCnt = 0; mPh = 0; mBlank = 0; mWide = w;
    end else if (p) begin
      if (mPh == 0) mPh = 1;
      else begin
        mPh = 0;
        last = mWide ? 8'hB6 : 8'h93;
        if (mCnt == 8'hFF) begin
          mCnt = 0; mWide = w;
        end else if (mCnt == last) begin
          mCnt = mWide ? 8'hE4 : 8'hE9; mBlank = 1;
        end else begin
          mCnt++;
          if (mCnt == (mWide ? 8 : 6)) mBlank = 0;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic measureLine(input bit w, input int expPix, input string tag);
    int n = 0;
    for (int i = 0; i < 1000 && !sawHint; i++) step(1, w, 0, 0);
    do begin
      step(1, w, 0, 0);
      n++;
    end while (!sawHint && n < 1000);
    cmp(n, expPix, tag);
  endtask

  initial begin
    #1600000;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    @(negedge clk);
    step(0, 0, 0, 1);
    step(1, 0, 0, 1);
    // R1 reset state
    cmp(hCount, 0, "R1 reset hCount");
    cmp(hBlank, 0, "R1 reset hBlank");
    cmp(hSyncN, 1, "R1 reset hSyncN");

    // narrow line, continuous enable
    for (int i = 0; i < 800; i++) step(1, 0, 0, 0);
    sawHint = 0;
    measureLine(0, 342, "R3 narrow line pixels");

    // switch to wide: takes effect at next wrap (R5)
    for (int i = 0; i < 900; i++) step(1, 1, 0, 0);
    sawHint = 0;
    measureLine(1, 422, "R4 wide line pixels");

    // sync held off for a full wide line (R11)
    for (int i = 0; i < 450; i++) step(1, 1, 1, 0);

    // random enable gaps, mid-line width flips, sync disable
    for (int i = 0; i < 40000; i++) begin
      bit p = ($urandom % 4) != 0;
      bit w = (i / 3000) % 2 == 1 ? (($urandom % 50) != 0) : (($urandom % 50) == 0);
      bit s = ($urandom % 20) == 0;
      step(p, w, s, 0);
    end

    // reset in mid-line, reloading wide mode (R1)
    step(1, 1, 0, 1);
    cmp(hCount, 0, "R1 mid-line reset hCount");
    cmp(hBlank, 0, "R1 mid-line reset hBlank");
    for (int i = 0; i < 900; i++) step(1, 1, 0, 0);
    sawHint = 0;
    measureLine(1, 422, "R4 wide after reset");

    // long enable gaps: position must hold (R2)
    for (int i = 0; i < 3000; i++) step(($urandom % 8) == 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule